// File: doc/BRIEF.md
# Flash Busy Status Read Generator

This block produces the byte a host sees when it reads a parallel NOR-style flash while an embedded program or erase is in flight. A one-cycle launch request, qualified by an operation type and the byte being programmed, opens a busy window whose length comes from a cycle count chosen per operation. The cycle counts stand in for the real program and erase durations.

During that window, each read strobe returns a status byte instead of array contents. The top bit is a polarity flag. For a byte program it is the inverse of the top bit of the byte being programmed. For an erase it is zero. The next bit down flips on every read access, so a host can poll with plain reads and see completion when the flag matches the expected data or the flipping bit holds still. Once the window closes, reads pass the array byte through untouched. The memory array, its analog timing and the real erase pulses sit outside this block.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` is all zeros.
- R2: A `start` pulse seen while `busy` is 0 makes `busy` high from the next cycle for exactly PROG_CYCLES cycles when `op_erase` is 0 (byte program), or for exactly ERASE_CYCLES cycles when `op_erase` is 1 (erase).
- R3: A `start` pulse seen while `busy` is 1 is ignored. The window keeps its length and its operation type. The stored byte is not replaced.
- R4: During a program window, a read returns in bit DW-1 the inverse of bit DW-1 of `load_data` as sampled with the accepted `start`.
- R5: During an erase window, a read returns 0 in bit DW-1.
- R6: During a window, bit DW-2 of successive reads alternates, and only read strobes advance it.
- R7: During a window, all bits below DW-2 read as 0.
- R8: Outside a window, a read returns `array_data` exactly as sampled with the strobe, and such reads do not advance the alternating bit.
- R9: `rd_data` changes only in the cycle after a clock edge that samples `rd_strobe` high, and holds its value otherwise.
- R10: Each accepted `start` clears the alternating bit, so the first read of any window returns 0 in bit DW-2, whatever the previous window left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_erase | input | 1 | Operation type sampled with start: 0 program, 1 erase |
| load_data | input | DW | Byte being programmed, sampled with start |
| rd_strobe | input | 1 | One read access (a chip-enable or output-enable toggle) |
| array_data | input | DW | Array contents at the read address |
| rd_data | output | DW | Registered read result |
| busy | output | 1 | High while an operation is running |

## Verification
The bench builds the block with PROG_CYCLES of 6 and ERASE_CYCLES of 20. These short windows let it count the exact length of every window in both modes. They also leave room for several reads inside one window, so the alternating bit can be followed across three or more accesses. Back-to-back windows become cheap, so a window that ends with the alternating bit high can be followed at once by a new one, which tests the clear on launch. A start issued in the middle of a window, with the opposite operation type and opposite data, shows that the window length and the polarity bit both stay unchanged.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } fbs_op_e;
endpackage

// File: rtl/fbs_timer.sv
module fbs_timer
  import fbs_pkg::*;
#(
  parameter int PROG_CYCLES  = 50,
  parameter int ERASE_CYCLES = 400
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    launch,
  input  fbs_op_e op,
  output logic    busy
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = (op == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/fbs_toggle.sv
module fbs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic tog
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (clear)        tog_d = 1'b0;
    else if (advance) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog = tog_q;
endmodule

// File: rtl/fbs_status.sv
module fbs_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic          busy,
  input  logic          poll_bit,
  input  logic          tog,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_POS = DW - 1;
  localparam int TOG_POS  = DW - 2;

  logic [DW-1:0] status_word;
  logic [DW-1:0] rd_q, rd_d;

  always_comb begin
    status_word           = '0;
    status_word[POLL_POS] = poll_bit;
    status_word[TOG_POS]  = tog;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_strobe) rd_d = busy ? status_word : array_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fbs_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 50,
  parameter int ERASE_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [DW-1:0] load_data,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  fbs_op_e op_in, op_q, op_d;
  logic    msb_q, msb_d;
  logic    launch;
  logic    tog;
  logic    poll_bit;

  assign op_in  = op_erase ? OP_ERASE : OP_PROG;
  assign launch = start & ~busy;

  always_comb begin
    op_d  = op_q;
    msb_d = msb_q;
    if (launch) begin
      op_d  = op_in;
      msb_d = load_data[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_PROG;
      msb_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      msb_q <= msb_d;
    end
  end

  assign poll_bit = (op_q == OP_ERASE) ? 1'b0 : ~msb_q;

  fbs_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .op    (op_in),
    .busy  (busy)
  );

  fbs_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch),
    .advance(rd_strobe & busy),
    .tog    (tog)
  );

  fbs_status #(.DW(DW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .busy      (busy),
    .poll_bit  (poll_bit),
    .tog       (tog),
    .array_data(array_data),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk
  import fbs_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_strobe,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input fbs_op_e       op_q
);
  AST_START_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(op_q)); // R3

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy && op_q == OP_ERASE) |=> !rd_data[DW-1]); // R5

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && busy) |=> (rd_data[DW-3:0] == '0)); // R7

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !busy) |=> (rd_data == $past(array_data))); // R8

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data)); // R9
endmodule

bind flash_busy_status flash_busy_status_chk #(.DW(DW)) u_chk (.*);

// File: tb/flash_busy_status_test.sv
module flash_busy_status_test;
  localparam int DW    = 8;
  localparam int PROG  = 6;
  localparam int ERASE = 20;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic [DW-1:0] load_data = '0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int checks = 0;
  int errors = 0;
  item_t sb[$];

  // reference state built from the requirements
  logic m_busy, m_erase, m_msb, m_tog;
  int   m_left;

  always #4 clk = ~clk;

  flash_busy_status #(.DW(DW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .load_data(load_data), .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data), .busy(busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_erase <= 1'b0; m_msb <= 1'b0; m_tog <= 1'b0; m_left <= 0;
    end else if (m_busy) begin
      if (m_left == 1) m_busy <= 1'b0;
      else             m_left <= m_left - 1;
      if (rd_strobe) m_tog <= ~m_tog;
    end else if (start) begin
      m_busy  <= 1'b1;
      m_left  <= op_erase ? ERASE : PROG;
      m_erase <= op_erase;
      m_msb   <= load_data[DW-1];
      m_tog   <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result in the cycle after its strobe
  always begin
    @(posedge clk);
    if (rst_n && rd_strobe) begin
      @(negedge clk);
      if (sb.size() == 0) check("R9 unexpected read", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic do_read(input logic [DW-1:0] arr, input string tag);
    item_t it;
    @(negedge clk);
    array_data = arr;
    rd_strobe  = 1'b1;
    if (m_busy) begin
      it.exp = '0;
      it.exp[DW-1] = m_erase ? 1'b0 : ~m_msb;
      it.exp[DW-2] = m_tog;
    end else begin
      it.exp = arr;
    end
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic launch(input logic er, input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1; op_erase = er; load_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic timed(input logic er, input logic [DW-1:0] d, input bit extra, input string tag);
    int n;
    launch(er, d);
    if (extra) begin
      start = 1'b1; op_erase = ~er; load_data = ~d;
    end
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
      start = 1'b0;
    end
    check(tag, n, er ? ERASE : PROG);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", rd_data, 0);
    check("R1 busy after reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(8'hA5, "R8 idle pass A5");
    do_read(8'h3C, "R8 idle pass 3C");
    array_data = 8'h77;
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", rd_data, 8'h3C);

    timed(1'b0, 8'h80, 1'b0, "R2 program window length");
    timed(1'b1, 8'h00, 1'b0, "R2 erase window length");
    timed(1'b0, 8'h00, 1'b1, "R3 window length kept on busy start");

    launch(1'b0, 8'h80);
    do_read(8'hFF, "R4 R6 R7 program read 1 (bit7=0 bit6=0)");
    do_read(8'hFF, "R6 program read 2 (bit6=1)");
    do_read(8'hFF, "R6 program read 3 (bit6=0)");
    wait_idle();
    do_read(8'h5A, "R8 after program done");
    do_read(8'h5A, "R8 no toggle when idle");

    launch(1'b0, 8'h00);
    launch(1'b1, 8'h80);
    do_read(8'hFF, "R3 R4 busy start ignored (bit7=1)");
    wait_idle();

    launch(1'b1, 8'hFF);
    do_read(8'h00, "R5 R7 erase read 1");
    do_read(8'h00, "R5 R6 erase read 2");
    do_read(8'h00, "R5 R6 erase read 3");
    do_read(8'h00, "R6 erase read 4 (bit6=1)");
    wait_idle();
    do_read(8'hFF, "R8 erased array reads FF");

    launch(1'b0, 8'h7F);
    do_read(8'h12, "R10 first read after new launch bit6=0");
    do_read(8'h12, "R6 second read bit6=1");
    wait_idle();

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule